// File: doc/BRIEF.md
# ADC Input Multiplexer Sequencer

This controller drives the select lines of an analog input multiplexer that feeds a single delta-sigma converter. Each conversion pass visits four slots. On entering a slot the block raises a one-cycle filter start. It then holds the slot until the decimation filter reports done, and moves on. It runs in the 32.768 kHz clock domain. A pass begins only when the compute engine signals the start of a new program pass.

A normal pass samples both phase currents and both phase voltages. Software may ask for an alternate pass. That pass replaces the first current with the die temperature sensor and the second current with the battery voltage. Voltage A stays in slot 1, so the voltage tracking path downstream keeps receiving its samples. An alternate request is held until the next pass begins and then covers that one pass only. The battery monitor is powered only while its slot is selected, and only if the host has set the battery-monitor permission bit.

The block has no data stream. All of its pins are plain level or pulse controls, and none of them uses a valid/ready handshake or back-pressure.

Top module: `adc_mux_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the block is idle: `filt_start`, `pass_done`, `alt_pass` and `batt_mon_en` are 0, `slot_idx` is 0 and no alternate request is pending.
- R2: A `pass_start` pulse sampled while idle begins a pass. In the next cycle `slot_idx` is 0 and `filt_start` is 1 for exactly one cycle.
- R3: Within a pass the slot advances only on a clock edge that samples `filt_done` high while the block is waiting. Each new slot raises `filt_start` for exactly one cycle in the cycle it is entered. While the block waits, `filt_start` is 0.
- R4: `chan_sel` codes are 0 current A, 1 voltage A, 2 current B, 3 voltage B, 4 temperature, 5 battery. A regular pass selects 0, 1, 2, 3 in slots 0 to 3.
- R5: An alternate pass selects 4, 1, 5, 3 in slots 0 to 3. Slot 1 selects code 1 in every pass.
- R6: `batt_mon_en` is 1 only when an alternate pass is in slot 2 and `batt_perm` is 1. With `batt_perm` at 0 the battery slot is still visited, but `batt_mon_en` stays 0.
- R7: An `alt_req` pulse is latched. It applies to the next pass that starts, including a pass whose start is sampled in the same cycle as the request. It covers exactly that one pass and then clears. `alt_pass` is 1 throughout that pass and 0 otherwise. A request made during a pass does not change the pass in progress.
- R8: After `filt_done` is sampled in slot 3, `pass_done` is 1 for exactly one cycle, the block returns to idle with `slot_idx` 0, and it issues no `filt_start` until the next `pass_start`.
- R9: A `pass_start` pulse that arrives during a pass is ignored. The slot does not change, no `filt_start` is issued, and no extra pass follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| pass_start | input | 1 | Pulse from the compute engine at the start of each program pass |
| alt_req | input | 1 | Software pulse asking for one alternate pass |
| batt_perm | input | 1 | Host permission bit for the battery monitor |
| filt_done | input | 1 | Decimation filter finished for the current slot |
| filt_start | output | 1 | One-cycle pulse that starts the filter for a new slot |
| chan_sel | output | 3 | Analog multiplexer channel code |
| slot_idx | output | 2 | Current slot number, 0 to 3 |
| batt_mon_en | output | 1 | Battery monitor enable |
| alt_pass | output | 1 | High during an alternate pass |
| pass_done | output | 1 | One-cycle strobe when a pass completes |

## Verification
Any corruption of the slot counter shows up on `chan_sel` and `slot_idx` in the same cycle. A stuck wait state shows as a missing `filt_start` within one cycle of the done pulse. A pending-request bit that is lost or never clears makes `alt_pass` wrong on the very next pass. The bench checks every slot of every pass against a model built from the channel tables, and it checks the cycles right around each `filt_done` and each `pass_done`. Because of that, each of these faults is reported within a single pass.

// File: rtl/mxseq_pkg.sv
package mxseq_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int SEL_W     = 3;

  localparam logic [SEL_W-1:0] CH_IA   = 3'd0;
  localparam logic [SEL_W-1:0] CH_VA   = 3'd1;
  localparam logic [SEL_W-1:0] CH_IB   = 3'd2;
  localparam logic [SEL_W-1:0] CH_VB   = 3'd3;
  localparam logic [SEL_W-1:0] CH_TEMP = 3'd4;
  localparam logic [SEL_W-1:0] CH_BAT  = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } seq_state_e;

  function automatic logic [SEL_W-1:0] regular_chan(input int slot);
    case (slot)
      0:       return CH_IA;
      1:       return CH_VA;
      2:       return CH_IB;
      default: return CH_VB;
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] alternate_chan(input int slot);
    case (slot)
      0:       return CH_TEMP;
      1:       return CH_VA;
      2:       return CH_BAT;
      default: return CH_VB;
    endcase
  endfunction
endpackage

// File: rtl/mxseq_req_latch.sv
module mxseq_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic alt_req,
  input  logic take,
  output logic alt_grant
);
  logic pend_q;

  assign alt_grant = pend_q | alt_req;

  always_ff @(posedge clk) begin
    if (rst)       pend_q <= 1'b0;
    else if (take) pend_q <= 1'b0;
    else           pend_q <= pend_q | alt_req;
  end

  // R7
  one_shot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !alt_req) |=> !pend_q);
endmodule

// File: rtl/mxseq_chan_map.sv
module mxseq_chan_map
  import mxseq_pkg::*;
(
  input  logic              alt,
  input  logic [SLOT_W-1:0] slot,
  output logic [SEL_W-1:0]  chan_sel,
  output logic              batt_slot
);
  logic [SEL_W-1:0] reg_tab [NUM_SLOTS];
  logic [SEL_W-1:0] alt_tab [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_tab
    assign reg_tab[g] = regular_chan(g);
    assign alt_tab[g] = alternate_chan(g);
  end

  always_comb begin
    chan_sel  = alt ? alt_tab[slot] : reg_tab[slot];
    batt_slot = alt && (alt_tab[slot] == CH_BAT);
  end
endmodule

// File: rtl/mxseq_ctrl.sv
module mxseq_ctrl
  import mxseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_start,
  input  logic              filt_done,
  input  logic              alt_grant,
  output logic              take,
  output logic              busy,
  output logic              filt_start,
  output logic [SLOT_W-1:0] slot,
  output logic              alt_pass,
  output logic              pass_done
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  seq_state_e        st_q;
  logic [SLOT_W-1:0] slot_q;
  logic              alt_q;
  logic              done_q;

  assign take       = (st_q == ST_IDLE) && pass_start;
  assign busy       = (st_q != ST_IDLE);
  assign filt_start = (st_q == ST_LAUNCH);
  assign slot       = slot_q;
  assign alt_pass   = alt_q;
  assign pass_done  = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      alt_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (pass_start) begin
            st_q   <= ST_LAUNCH;
            slot_q <= '0;
            alt_q  <= alt_grant;
          end
        end
        ST_LAUNCH: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (filt_done) begin
            if (slot_q == LAST_SLOT) begin
              st_q   <= ST_IDLE;
              slot_q <= '0;
              alt_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              st_q   <= ST_LAUNCH;
              slot_q <= slot_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    filt_start |=> !filt_start);
  // R3
  hold_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !filt_done) |=> $stable(slot_q));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R7
  alt_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !(st_q == ST_WAIT && filt_done && slot_q == LAST_SLOT)) |=> $stable(alt_q));
endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
  import mxseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_start,
  input  logic              alt_req,
  input  logic              batt_perm,
  input  logic              filt_done,
  output logic              filt_start,
  output logic [SEL_W-1:0]  chan_sel,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              batt_mon_en,
  output logic              alt_pass,
  output logic              pass_done
);
  logic take, busy, alt_grant, batt_slot;

  mxseq_req_latch u_req (
    .clk(clk), .rst(rst), .alt_req(alt_req), .take(take), .alt_grant(alt_grant)
  );

  mxseq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .pass_start(pass_start), .filt_done(filt_done),
    .alt_grant(alt_grant), .take(take), .busy(busy), .filt_start(filt_start),
    .slot(slot_idx), .alt_pass(alt_pass), .pass_done(pass_done)
  );

  mxseq_chan_map u_map (
    .alt(alt_pass), .slot(slot_idx), .chan_sel(chan_sel), .batt_slot(batt_slot)
  );

  assign batt_mon_en = busy && batt_slot && batt_perm;

  // R6
  batt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    batt_mon_en |-> (batt_perm && alt_pass && chan_sel == CH_BAT));
  // R5
  va_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && slot_idx == 2'd1) |-> (chan_sel == CH_VA));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!filt_start && !alt_pass && !batt_mon_en && slot_idx == '0));
endmodule

// File: tb/sim_adc_mux_sequencer.sv
module sim_adc_mux_sequencer;
  logic clk = 1'b0, rst = 1'b1;
  logic pass_start = 0, alt_req = 0, batt_perm = 0, filt_done = 0;
  logic filt_start, batt_mon_en, alt_pass, pass_done;
  logic [2:0] chan_sel;
  logic [1:0] slot_idx;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  adc_mux_sequencer u0 (
    .clk(clk), .rst(rst), .pass_start(pass_start), .alt_req(alt_req),
    .batt_perm(batt_perm), .filt_done(filt_done), .filt_start(filt_start),
    .chan_sel(chan_sel), .slot_idx(slot_idx), .batt_mon_en(batt_mon_en),
    .alt_pass(alt_pass), .pass_done(pass_done)
  );

  // vector: {alt_mode[1:0], batt_perm, done_delay[2:0], exp_alt, exp_chans[11:0]}
  // alt_mode: 0 none, 1 request with start, 2 request one cycle before start
  typedef struct packed {
    logic [1:0]  mode;
    logic        perm;
    logic [2:0]  dly;
    logic        ealt;
    logic [11:0] chans;
  } vec_t;
  localparam vec_t VECS [7] = '{
    '{2'd0, 1'b0, 3'd0, 1'b0, {3'd3, 3'd2, 3'd1, 3'd0}},
    '{2'd2, 1'b1, 3'd2, 1'b1, {3'd3, 3'd5, 3'd1, 3'd4}},
    '{2'd0, 1'b1, 3'd1, 1'b0, {3'd3, 3'd2, 3'd1, 3'd0}},
    '{2'd1, 1'b0, 3'd3, 1'b1, {3'd3, 3'd5, 3'd1, 3'd4}},
    '{2'd1, 1'b1, 3'd0, 1'b1, {3'd3, 3'd5, 3'd1, 3'd4}},
    '{2'd0, 1'b0, 3'd5, 1'b0, {3'd3, 3'd2, 3'd1, 3'd0}},
    '{2'd2, 1'b0, 3'd1, 1'b1, {3'd3, 3'd5, 3'd1, 3'd4}}
  };

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Runs one pass from idle; assumes inputs are low on entry.
  task automatic run_pass(input vec_t v);
    batt_perm = v.perm;
    if (v.mode == 2'd2) begin alt_req = 1; tick(); alt_req = 0; end
    pass_start = 1; alt_req = (v.mode == 2'd1);
    tick();
    pass_start = 0; alt_req = 0;
    for (int s = 0; s < 4; s++) begin
      int ec = int'(v.chans[s*3 +: 3]);
      chk(filt_start, 1, "R2/R3 start pulse");
      chk(slot_idx, s, "R3 slot");
      chk(chan_sel, ec, v.ealt ? "R5 alt chan" : "R4 reg chan");
      chk(alt_pass, v.ealt, "R7 alt flag");
      chk(batt_mon_en, (v.ealt && s == 2 && v.perm) ? 1 : 0, "R6 batt en");
      tick();
      chk(filt_start, 0, "R3 no start while waiting");
      repeat (v.dly) begin tick(); chk(slot_idx, s, "R3 hold"); end
      filt_done = 1; tick(); filt_done = 0;
    end
    chk(pass_done, 1, "R8 pass done");
    chk(slot_idx, 0, "R8 slot idle");
    tick();
    chk(pass_done, 0, "R8 done single");
    chk(filt_start, 0, "R8 idle no start");
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", wd);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) tick();
    // R1 during reset
    chk(filt_start, 0, "R1 start"); chk(slot_idx, 0, "R1 slot");
    chk(alt_pass, 0, "R1 alt"); chk(batt_mon_en, 0, "R1 batt");
    chk(pass_done, 0, "R1 done");
    rst = 0; tick();
    chk(filt_start, 0, "R1 after release");

    foreach (VECS[i]) run_pass(VECS[i]);

    // R9: mid-pass start ignored; R7: mid-pass request waits for next pass
    pass_start = 1; tick(); pass_start = 0;
    tick();
    filt_done = 1; tick(); filt_done = 0;
    chk(slot_idx, 1, "R3 advanced");
    tick();
    pass_start = 1; alt_req = 1; tick(); pass_start = 0; alt_req = 0;
    chk(slot_idx, 1, "R9 slot held");
    chk(filt_start, 0, "R9 no start");
    chk(alt_pass, 0, "R7 current pass unchanged");
    for (int s = 1; s < 4; s++) begin
      filt_done = 1; tick(); filt_done = 0;
      if (s < 3) tick();
    end
    chk(pass_done, 1, "R8 done");
    repeat (3) begin tick(); chk(filt_start, 0, "R9 no extra pass"); end
    run_pass('{2'd0, 1'b1, 3'd0, 1'b1, {3'd3, 3'd5, 3'd1, 3'd4}});
    run_pass('{2'd0, 1'b1, 3'd0, 1'b0, {3'd3, 3'd2, 3'd1, 3'd0}});

    // R1: reset clears a pending request
    alt_req = 1; tick(); alt_req = 0;
    rst = 1; tick(); tick(); rst = 0; tick();
    chk(alt_pass, 0, "R1 reset alt");
    run_pass('{2'd0, 1'b1, 3'd1, 1'b0, {3'd3, 3'd2, 3'd1, 3'd0}});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule